// File: doc/BRIEF.md
# Link Clock Frequency Checker

This block measures the frequency of a recovered parallel clock from a serial link. It compares the measurement against the frequency that the current link configuration calls for. A free-running reference clock times a fixed counting window. During that window, a counter running on the clock under test counts its rising edges. When the window closes, the count is carried back into the reference domain and checked against an expected count. The expected count is chosen by a 2-bit link-rate code and a dual/quad symbols-per-clock select.

Measurements repeat back to back. Each one ends with a single-cycle done pulse, which presents the measured count and a pass flag. The pass flag is high when the count lies within one percent of the expected value. A clock under test that has stopped cannot return a count. In that case the measurement still completes after a bounded wait, reporting a zero count and a failure.

Top module: `lcfc_link_clk_checker`

## Requirements
- R1: While reset is high and until the first measurement completes, `done`, `pass` and `meas_count` are all zero.
- R2: Each measurement counts the rising edges of `cut_clk` during a window of `WINDOW_CYCLES` reference cycles. The reported count lies within ±2 of f_cut × `WINDOW_CYCLES` / f_ref.
- R3: The expected lane clock is chosen by the rate code and the symbol select. The rate code is 00 for 1.62 Gb/s, 01 for 2.7 Gb/s and 10 for 5.4 Gb/s. With `quad_sym`=0 (two symbols per clock) the expected clocks are 81, 135 and 270 MHz. With `quad_sym`=1 (four symbols per clock) they are 40.5, 67.5 and 135 MHz. The expected count is target_kHz × `WINDOW_CYCLES` / `REF_KHZ`, rounded down.
- R4: `pass` is 1 exactly when |count − expected| ≤ floor(expected / 100).
- R5: Rate code 11 always gives `pass` = 0.
- R6: `done` is high for exactly one reference cycle per measurement. `meas_count` and `pass` change only in that cycle and hold their values between pulses. Each measurement starts as soon as the previous one completes.
- R7: The rate code and symbol select are captured when a window opens. A change made while a window is open affects only the next measurement.
- R8: If no count returns within `ACK_TIMEOUT` reference cycles after a window closes, the measurement completes with `meas_count` = 0 and `pass` = 0.
- R9: After a stopped `cut_clk` starts running again, correct measurements resume within three completed measurements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| cut_clk | input | 1 | Recovered clock under test |
| link_rate | input | 2 | Link-rate code (00, 01, 10; 11 invalid) |
| quad_sym | input | 1 | 0: two symbols per clock, 1: four symbols per clock |
| meas_count | output | CNT_W | Edge count of the last completed window |
| pass | output | 1 | Last measurement was within tolerance |
| done | output | 1 | One-cycle pulse when a measurement completes |

## Verification
A result is due one window plus the return handshake after its window opens. The handshake takes two synchronizer stages on the test clock, one capture edge, two synchronizer stages on the reference clock and one output register. That makes the spacing between pulses depend on the test clock, so the checks do not count cycles. Instead, the scoreboard pops one expected item per `done` pulse and samples the outputs on the falling reference edge of that pulse cycle. The stimulus driver changes settings only just after a pulse. It queues a discard item for the window already in flight, because that window still carries the old settings. The first check after the settings change is made on the measurement that follows.

// File: rtl/lcfc_pkg.sv
`timescale 1ns/1ps
package lcfc_pkg;

    typedef enum logic [1:0] {
        RATE_LOW  = 2'b00,
        RATE_MID  = 2'b01,
        RATE_HIGH = 2'b10,
        RATE_BAD  = 2'b11
    } lrate_e;

    // Bit order matters: {rate, quad} indexes the expected-count table.
    typedef struct packed {
        lrate_e rate;
        logic   quad;
    } lset_t;

    typedef enum logic {
        PH_COUNT = 1'b0,
        PH_WAIT  = 1'b1
    } phase_e;

    // Symbol rate in kHz is the line rate divided by 10 bits per symbol.
    function automatic longint unsigned symbol_khz(lrate_e r);
        case (r)
            RATE_LOW:  return 64'd162000;
            RATE_MID:  return 64'd270000;
            RATE_HIGH: return 64'd540000;
            default:   return 64'd0;
        endcase
    endfunction

    // Edges expected in one window for a given lane configuration.
    function automatic logic [31:0] expected_count(lset_t s, int unsigned window,
                                                   int unsigned ref_khz);
        longint unsigned lane_khz;
        lane_khz = s.quad ? symbol_khz(s.rate) / 4 : symbol_khz(s.rate) / 2;
        return 32'(lane_khz * longint'(window) / longint'(ref_khz));
    endfunction

endpackage

// File: rtl/lcfc_sync2.sv
`timescale 1ns/1ps
module lcfc_sync2 #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/lcfc_window_ctl.sv
`timescale 1ns/1ps
module lcfc_window_ctl
    import lcfc_pkg::*;
#(
    parameter int WINDOW_CYCLES = 10000,
    parameter int ACK_TIMEOUT   = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  lset_t set_in,
    input  logic  ack_tog,
    output logic  win_en,
    output logic  smp_valid,
    output logic  smp_ok,
    output lset_t smp_set
);
    localparam int WC_W = $clog2(WINDOW_CYCLES + 1);
    localparam int TO_W = $clog2(ACK_TIMEOUT + 1);

    phase_e          phase;
    logic [WC_W-1:0] win_cnt;
    logic [TO_W-1:0] wait_cnt;
    lset_t           cur_set;
    logic            tog_seen;
    logic            ack_seen;

    assign ack_seen = (ack_tog != tog_seen);
    assign win_en   = (phase == PH_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_COUNT;
            win_cnt   <= '0;
            wait_cnt  <= '0;
            cur_set   <= set_in;
            tog_seen  <= ack_tog;
            smp_valid <= 1'b0;
            smp_ok    <= 1'b0;
            smp_set   <= '0;
        end else begin
            smp_valid <= 1'b0;
            case (phase)
                PH_COUNT: begin
                    // Toggles that arrive while counting are stale: absorb them.
                    tog_seen <= ack_tog;
                    if (win_cnt == WC_W'(WINDOW_CYCLES - 1)) begin
                        phase    <= PH_WAIT;
                        win_cnt  <= '0;
                        wait_cnt <= '0;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                default: begin
                    if (ack_seen || wait_cnt == TO_W'(ACK_TIMEOUT - 1)) begin
                        smp_valid <= 1'b1;
                        smp_ok    <= ack_seen;
                        smp_set   <= cur_set;
                        tog_seen  <= ack_tog;
                        cur_set   <= set_in;
                        phase     <= PH_COUNT;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assert_window_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(win_en) |-> $past(win_cnt) == WC_W'(WINDOW_CYCLES - 1));

    assert_timeout_reports_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT && wait_cnt == TO_W'(ACK_TIMEOUT - 1)) |=> smp_valid);

    assert_settings_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COUNT && $past(phase == PH_COUNT)) |-> $stable(cur_set));
endmodule

// File: rtl/lcfc_cut_counter.sv
`timescale 1ns/1ps
module lcfc_cut_counter #(
    parameter int CNT_W = 17
) (
    input  logic             cut_clk,
    input  logic             rst,
    input  logic             win_en,
    output logic [CNT_W-1:0] hold_cnt,
    output logic             hold_tog
);
    logic             rst_c;
    logic             en_s;
    logic             en_d;
    logic [CNT_W-1:0] run_cnt;

    lcfc_sync2 #(.WIDTH(1), .STAGES(2)) u_rst_sync (
        .clk(cut_clk), .rst(1'b0), .d(rst), .q(rst_c));

    lcfc_sync2 #(.WIDTH(1), .STAGES(2)) u_en_sync (
        .clk(cut_clk), .rst(rst_c), .d(win_en), .q(en_s));

    always_ff @(posedge cut_clk) begin
        if (rst_c) begin
            en_d     <= 1'b0;
            run_cnt  <= '0;
            hold_cnt <= '0;
            hold_tog <= 1'b0;
        end else begin
            en_d <= en_s;
            if (en_s) begin
                if (run_cnt != '1) run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
                if (en_d) begin
                    hold_cnt <= run_cnt;
                    hold_tog <= ~hold_tog;
                end
            end
        end
    end

    assert_hold_frozen_R2: assert property (@(posedge cut_clk) disable iff (rst_c !== 1'b0)
        en_s |=> $stable(hold_cnt));

    assert_close_toggles_R2: assert property (@(posedge cut_clk) disable iff (rst_c !== 1'b0)
        $fell(en_s) |=> hold_tog != $past(hold_tog));
endmodule

// File: rtl/lcfc_judge.sv
`timescale 1ns/1ps
module lcfc_judge
    import lcfc_pkg::*;
#(
    parameter int WINDOW_CYCLES = 10000,
    parameter int REF_KHZ       = 100000,
    parameter int CNT_W         = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic             smp_ok,
    input  lset_t            smp_set,
    input  logic [CNT_W-1:0] hold_cnt,
    output logic [CNT_W-1:0] meas_count,
    output logic             pass,
    output logic             done
);
    localparam int SET_W = $bits(lset_t);
    localparam int NSET  = 1 << SET_W;

    logic [31:0]      exp_tbl [NSET];
    logic [31:0]      tol_tbl [NSET];
    logic [SET_W-1:0] sel;
    logic [31:0]      meas_w, exp_w, tol_w, diff_w;
    logic             in_tol;

    for (genvar g = 0; g < NSET; g++) begin : g_ref
        localparam lset_t       G_SET = lset_t'(SET_W'(g));
        localparam logic [31:0] G_EXP = expected_count(G_SET, WINDOW_CYCLES, REF_KHZ);
        assign exp_tbl[g] = G_EXP;
        assign tol_tbl[g] = G_EXP / 32'd100;
    end

    assign sel    = smp_set;
    assign exp_w  = exp_tbl[sel];
    assign tol_w  = tol_tbl[sel];
    assign meas_w = 32'(hold_cnt);
    assign diff_w = (meas_w > exp_w) ? (meas_w - exp_w) : (exp_w - meas_w);
    assign in_tol = (exp_w != 32'd0) && (diff_w <= tol_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            meas_count <= '0;
            pass       <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= smp_valid;
            if (smp_valid) begin
                meas_count <= smp_ok ? hold_cnt : '0;
                pass       <= smp_ok && in_tol;
            end
        end
    end

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_outputs_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(meas_count) && $stable(pass)));

    assert_bad_rate_fails_R5: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_set.rate == RATE_BAD) |=> !pass);

    assert_timeout_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !smp_ok) |=> (meas_count == '0 && !pass));
endmodule

// File: rtl/lcfc_link_clk_checker.sv
`timescale 1ns/1ps
module lcfc_link_clk_checker
    import lcfc_pkg::*;
#(
    parameter int WINDOW_CYCLES = 10000,
    parameter int REF_KHZ       = 100000,
    parameter int ACK_TIMEOUT   = 64,
    parameter int CNT_W         = $clog2(WINDOW_CYCLES * 4) + 1
) (
    input  logic             ref_clk,
    input  logic             rst,
    input  logic             cut_clk,
    input  logic [1:0]       link_rate,
    input  logic             quad_sym,
    output logic [CNT_W-1:0] meas_count,
    output logic             pass,
    output logic             done
);
    lset_t            set_in;
    lset_t            smp_set;
    logic             win_en;
    logic             smp_valid;
    logic             smp_ok;
    logic             hold_tog;
    logic             ack_tog;
    logic [CNT_W-1:0] hold_cnt;

    assign set_in.rate = lrate_e'(link_rate);
    assign set_in.quad = quad_sym;

    lcfc_window_ctl #(
        .WINDOW_CYCLES(WINDOW_CYCLES),
        .ACK_TIMEOUT  (ACK_TIMEOUT)
    ) u_ctl (
        .clk(ref_clk), .rst(rst), .set_in(set_in), .ack_tog(ack_tog),
        .win_en(win_en), .smp_valid(smp_valid), .smp_ok(smp_ok), .smp_set(smp_set));

    lcfc_cut_counter #(.CNT_W(CNT_W)) u_cut (
        .cut_clk(cut_clk), .rst(rst), .win_en(win_en),
        .hold_cnt(hold_cnt), .hold_tog(hold_tog));

    lcfc_sync2 #(.WIDTH(1), .STAGES(2)) u_ack_sync (
        .clk(ref_clk), .rst(rst), .d(hold_tog), .q(ack_tog));

    lcfc_judge #(
        .WINDOW_CYCLES(WINDOW_CYCLES),
        .REF_KHZ      (REF_KHZ),
        .CNT_W        (CNT_W)
    ) u_judge (
        .clk(ref_clk), .rst(rst), .smp_valid(smp_valid), .smp_ok(smp_ok),
        .smp_set(smp_set), .hold_cnt(hold_cnt),
        .meas_count(meas_count), .pass(pass), .done(done));
endmodule

// File: tb/lcfc_link_clk_checker_tb_top.sv
`timescale 1ns/1ps
module lcfc_link_clk_checker_tb_top;
    localparam int WIN     = 1000;
    localparam int REF_KHZ = 125000;
    localparam int TMO     = 64;
    localparam int CW      = $clog2(WIN * 4) + 1;

    logic          ref_clk = 1'b0;
    logic          cut_clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    link_rate = 2'b00;
    logic          quad_sym = 1'b0;
    logic [CW-1:0] meas_count;
    logic          pass;
    logic          done;

    real cut_half = 6.173;
    bit  cut_run  = 1'b1;

    always #4 ref_clk = ~ref_clk;

    initial begin
        forever begin
            if (cut_run) begin
                #(cut_half);
                cut_clk = ~cut_clk;
            end else begin
                #1;
            end
        end
    end

    lcfc_link_clk_checker #(
        .WINDOW_CYCLES(WIN), .REF_KHZ(REF_KHZ), .ACK_TIMEOUT(TMO), .CNT_W(CW)
    ) dut_i (
        .ref_clk(ref_clk), .rst(rst), .cut_clk(cut_clk), .link_rate(link_rate),
        .quad_sym(quad_sym), .meas_count(meas_count), .pass(pass), .done(done));

    typedef struct {
        bit    skip;
        real   nom;
        bit    exp_pass;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0, fails = 0, n_done = 0, pulse_viol = 0, stable_viol = 0, wd_cnt = 0;
    bit done_q = 1'b0, seen_done = 1'b0;
    logic [CW-1:0] last_meas = '0;
    logic          last_pass = 1'b0;

    task automatic check(bit ok, string tag, string what, real act, real exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0.2f expected=%0.2f", tag, what, act, exp);
        end
    endtask

    // Lane clock in MHz per R3, written as a plain table.
    function automatic real model_mhz(bit [1:0] r, bit q);
        case (r)
            2'b00:   return q ? 40.5 : 81.0;
            2'b01:   return q ? 67.5 : 135.0;
            2'b10:   return q ? 135.0 : 270.0;
            default: return 0.0;
        endcase
    endfunction

    function automatic sb_item_t mk_item(bit [1:0] r, bit q, real mhz, string tag);
        sb_item_t it;
        real tgt, expc, dev;
        tgt  = model_mhz(r, q);
        expc = $floor(tgt * WIN * 1000.0 / REF_KHZ);
        it.nom = (mhz > 0.0) ? mhz * WIN * 1000.0 / REF_KHZ : 0.0;
        dev = it.nom - expc;
        if (dev < 0.0) dev = -dev;
        it.skip     = 1'b0;
        it.exp_pass = (tgt > 0.0) && (mhz > 0.0) && (dev <= $floor(expc / 100.0));
        it.tag      = tag;
        return it;
    endfunction

    function automatic sb_item_t skip_item();
        sb_item_t it;
        it.skip = 1'b1; it.nom = 0.0; it.exp_pass = 1'b0; it.tag = "skip";
        return it;
    endfunction

    // Monitor: one scoreboard item per done pulse.
    always @(negedge ref_clk) begin
        if (!rst) begin
            if (done) begin
                sb_item_t it;
                real d;
                if (done_q) pulse_viol++;
                n_done++;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected done", 1.0, 0.0);
                end else begin
                    it = sb_q.pop_front();
                    if (!it.skip) begin
                        d = real'(meas_count) - it.nom;
                        if (d < 0.0) d = -d;
                        if (it.nom == 0.0)
                            check(meas_count == '0, it.tag, "meas_count", real'(meas_count), 0.0);
                        else
                            check(d <= 2.0, it.tag, "meas_count", real'(meas_count), it.nom);
                        check(pass == it.exp_pass, it.tag, "pass", real'(pass), real'(it.exp_pass));
                    end
                end
                seen_done = 1'b1;
            end else if (seen_done && (meas_count != last_meas || pass != last_pass)) begin
                stable_viol++;
            end
            last_meas = meas_count;
            last_pass = pass;
            done_q    = done;
        end
    end

    task automatic set_clk(real mhz);
        if (mhz <= 0.0) cut_run = 1'b0;
        else begin
            cut_half = 500.0 / mhz;
            cut_run  = 1'b1;
        end
    endtask

    task automatic wait_dones(int n);
        int tgt = n_done + n;
        while (n_done < tgt) @(posedge ref_clk);
        @(negedge ref_clk);
    endtask

    task automatic run_case(bit [1:0] r, bit q, real mhz, int skips, string tag);
        link_rate = r;
        quad_sym  = q;
        set_clk(mhz);
        for (int i = 0; i < skips; i++) sb_q.push_back(skip_item());
        sb_q.push_back(mk_item(r, q, mhz, tag));
        wait_dones(skips + 1);
    endtask

    always @(posedge ref_clk) wd_cnt++;

    initial begin
        wait (wd_cnt > 150000);
        check(1'b0, "WATCHDOG", "timeout", real'(wd_cnt), 150000.0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        set_clk(81.0);
        repeat (10) @(negedge ref_clk);
        check(done == 1'b0, "R1", "done in reset", real'(done), 0.0);
        check(pass == 1'b0, "R1", "pass in reset", real'(pass), 0.0);
        check(meas_count == '0, "R1", "meas in reset", real'(meas_count), 0.0);
        rst = 1'b0;
        repeat (20) @(negedge ref_clk);
        check(done == 1'b0 && meas_count == '0, "R1", "idle before first result",
              real'(meas_count), 0.0);

        // R2 R3: nominal clocks for every valid configuration
        run_case(2'b00, 1'b0, 81.0,  1, "R3 rate00 dual R2");
        run_case(2'b00, 1'b1, 40.5,  1, "R3 rate00 quad");
        run_case(2'b01, 1'b0, 135.0, 1, "R3 rate01 dual");
        run_case(2'b01, 1'b1, 67.5,  1, "R3 rate01 quad");
        run_case(2'b10, 1'b0, 270.0, 1, "R3 rate10 dual");
        run_case(2'b10, 1'b1, 135.0, 1, "R3 rate10 quad R2");

        // R4: inside and outside the one-percent band
        run_case(2'b00, 1'b0, 81.0 * 1.004,  1, "R4 slightly fast passes");
        run_case(2'b10, 1'b0, 270.0 * 0.98,  1, "R4 two percent slow fails");
        run_case(2'b01, 1'b1, 67.5 * 1.03,   1, "R4 three percent fast fails");
        run_case(2'b00, 1'b1, 81.0,          1, "R4 symbol select mismatch fails");

        // R5: invalid rate code
        run_case(2'b11, 1'b0, 81.0,  1, "R5 code11 dual");
        run_case(2'b11, 1'b1, 135.0, 1, "R5 code11 quad");

        // R7: change mid-window applies only to the next measurement
        run_case(2'b01, 1'b0, 135.0, 1, "R7 setup");
        sb_q.push_back(mk_item(2'b01, 1'b0, 135.0, "R7 window keeps old settings"));
        sb_q.push_back(mk_item(2'b11, 1'b0, 135.0, "R7 next window uses new code"));
        repeat (200) @(negedge ref_clk);
        link_rate = 2'b11;
        wait_dones(2);

        // R8: stopped clock gives zero count and fail
        run_case(2'b00, 1'b0, 0.0, 1, "R8 dead clock");
        run_case(2'b00, 1'b0, 0.0, 0, "R8 dead clock repeat");

        // R9: recovery once the clock runs again
        run_case(2'b00, 1'b0, 81.0, 2, "R9 recovery");

        check(pulse_viol == 0, "R6", "done wider than one cycle", real'(pulse_viol), 0.0);
        check(stable_viol == 0, "R6", "outputs moved without done", real'(stable_viol), 0.0);
        check(sb_q.size() == 0, "R6", "pending results", real'(sb_q.size()), 0.0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule